// File: doc/BRIEF.md
# Posted-Write Remote Access Controller

This controller lets a host processor write into a local processor's memory without being held in a wait state. External latches capture the host's address (16 bits) and data (8 bits) when the host's write strobe ends. The controller then closes the latches with a hold signal, asks the local side for its bus, and switches the bus over to the latched remote values. It pulses an internal write strobe and hands the bus back. The host gets no wait for a lone write, because the work starts only after its strobe is gone.

If the host begins another access while the posted write is still in flight, the ready line drops to stall it. The held latches protect the pending address and data. Ready returns on the same edge that the hold signal clears, so a queued access can complete on the next state. All control outputs are register outputs, so the latch enables and tri-state controls see no combinational glitches.

Top module: `remote_post_write`

## Requirements
- R1: After reset, wr_hold_n=1, sel_remote=0, loc_drv_en=1, int_we_n=1, host_rdy=1 and bus_req=0.
- R2: While idle, the clock edge that first samples host_wr_n high after sampling it low makes wr_hold_n go low and bus_req go high at that same edge.
- R3: A single posted write, with no host request during the transfer, leaves host_rdy high throughout.
- R4: sel_remote rises at the first edge that comes MIN_GAP (default 2) or more edges after wr_hold_n fell and that samples bus_gnt high. It is high only while wr_hold_n is low.
- R5: loc_drv_en is always the inverse of sel_remote, so local drivers are off whenever remote values own the bus.
- R6: int_we_n goes low for exactly STROBE_CYC (default 1) cycles, starting one edge after sel_remote rises.
- R7: sel_remote falls one edge after int_we_n rises. wr_hold_n rises and bus_req falls one edge after that.
- R8: host_req_n sampled low at an edge while a write is in flight, other than the edge where it completes, drives host_rdy low from that edge. host_rdy rises on the same edge as wr_hold_n.
- R9: A trailing edge of host_wr_n while a write is in flight is ignored and starts no further transfer.
- R10: A trailing edge sampled on the edge right after wr_hold_n rises starts a new transfer at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one state |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_n | input | 1 | Host write strobe, active low; latches capture on its rising edge |
| host_req_n | input | 1 | Host access request, active low |
| bus_gnt | input | 1 | Local bus grant |
| host_rdy | output | 1 | Ready to host; low stalls the host |
| wr_hold_n | output | 1 | Low while a write is pending; keeps the latches closed |
| sel_remote | output | 1 | Bus switch: 1 selects the latched remote address/data |
| loc_drv_en | output | 1 | Enable for local address/data drivers and address latch |
| int_we_n | output | 1 | Internal write strobe, active low |
| bus_req | output | 1 | Request for the local bus |

## Verification
The assertions assume that bus_gnt, once it has been given, causes no harm if it drops before the switch, and that the host strobes are synchronous to clk. The stimulus changes every input only at the falling clock edge. The stall checks assume that a stalled host keeps its write strobe low until ready returns. The bench holds to that in the queued-access case. In one deliberate case it breaks that rule, toggling the strobe while a write is in flight, to show that the toggle is ignored.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SWITCH,
        ST_STROBE,
        ST_DONE,
        ST_UNSWITCH
    } rpw_state_e;

    typedef struct packed {
        rpw_state_e st;
        logic       hold_n;
        logic       remote;
        logic       drv_en;
        logic       we_n;
        logic       rdy;
        logic       req;
    } rpw_ctl_t;

    localparam rpw_ctl_t RPW_CTL_RESET = '{
        st:     ST_IDLE,
        hold_n: 1'b1,
        remote: 1'b0,
        drv_en: 1'b1,
        we_n:   1'b1,
        rdy:    1'b1,
        req:    1'b0
    };

endpackage

// File: rtl/rpw_strobe_edge.sv
module rpw_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strobe_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise = strobe_n & ~prev_q;
endmodule

// File: rtl/rpw_span_timer.sv
module rpw_span_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && (cnt_q < LAST))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q >= LAST);
endmodule

// File: rtl/rpw_sequencer.sv
module rpw_sequencer
    import rpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_rise,
    input  logic       host_req_n,
    input  logic       bus_gnt,
    input  logic       gap_done,
    input  logic       strobe_done,
    output rpw_ctl_t   ctl_q
);
    rpw_ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_rise) begin
                    ctl_d.st     = ST_HOLD;
                    ctl_d.hold_n = 1'b0;
                    ctl_d.req    = 1'b1;
                end
            end
            ST_HOLD: begin
                if (gap_done && bus_gnt) begin
                    ctl_d.st     = ST_SWITCH;
                    ctl_d.remote = 1'b1;
                    ctl_d.drv_en = 1'b0;
                end
            end
            ST_SWITCH: begin
                ctl_d.st   = ST_STROBE;
                ctl_d.we_n = 1'b0;
            end
            ST_STROBE: begin
                if (strobe_done) begin
                    ctl_d.st   = ST_DONE;
                    ctl_d.we_n = 1'b1;
                end
            end
            ST_DONE: begin
                ctl_d.st     = ST_UNSWITCH;
                ctl_d.remote = 1'b0;
                ctl_d.drv_en = 1'b1;
            end
            ST_UNSWITCH: begin
                ctl_d.st     = ST_IDLE;
                ctl_d.hold_n = 1'b1;
                ctl_d.req    = 1'b0;
                ctl_d.rdy    = 1'b1;
            end
            default: ctl_d = RPW_CTL_RESET;
        endcase
        // stall a host that starts a new access while a write is in flight
        if ((ctl_q.st != ST_IDLE) && (ctl_d.st != ST_IDLE) && !host_req_n)
            ctl_d.rdy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= RPW_CTL_RESET;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/remote_post_write.sv
module remote_post_write
    import rpw_pkg::*;
#(
    parameter int MIN_GAP    = 2,
    parameter int STROBE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr_n,
    input  logic host_req_n,
    input  logic bus_gnt,
    output logic host_rdy,
    output logic wr_hold_n,
    output logic sel_remote,
    output logic loc_drv_en,
    output logic int_we_n,
    output logic bus_req
);
    logic     wr_rise;
    logic     gap_done;
    logic     strobe_done;
    rpw_ctl_t ctl_q;

    rpw_strobe_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (host_wr_n),
        .rise     (wr_rise)
    );

    rpw_span_timer #(.LIMIT(MIN_GAP)) i_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_q.st == ST_IDLE),
        .run   (ctl_q.st == ST_HOLD),
        .done  (gap_done)
    );

    rpw_span_timer #(.LIMIT(STROBE_CYC)) i_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_q.st != ST_STROBE),
        .run   (ctl_q.st == ST_STROBE),
        .done  (strobe_done)
    );

    rpw_sequencer i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_rise     (wr_rise),
        .host_req_n  (host_req_n),
        .bus_gnt     (bus_gnt),
        .gap_done    (gap_done),
        .strobe_done (strobe_done),
        .ctl_q       (ctl_q)
    );

    assign host_rdy   = ctl_q.rdy;
    assign wr_hold_n  = ctl_q.hold_n;
    assign sel_remote = ctl_q.remote;
    assign loc_drv_en = ctl_q.drv_en;
    assign int_we_n   = ctl_q.we_n;
    assign bus_req    = ctl_q.req;
endmodule

// File: rtl/rpw_checker.sv
module rpw_checker #(
    parameter int MIN_GAP = 2
) (
    input logic clk,
    input logic rst_n,
    input logic host_rdy,
    input logic wr_hold_n,
    input logic sel_remote,
    input logic loc_drv_en,
    input logic int_we_n,
    input logic bus_req
);
    logic [15:0] held_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || wr_hold_n)  held_cnt <= '0;
        else if (held_cnt != '1)  held_cnt <= held_cnt + 1'b1;
    end

    AST_DRV_INVERSE:  assert property (@(posedge clk) disable iff (!rst_n) loc_drv_en != sel_remote);                 // R5
    AST_SW_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n) sel_remote |-> !wr_hold_n);               // R4
    AST_SW_GAP:       assert property (@(posedge clk) disable iff (!rst_n) $rose(sel_remote) |-> (held_cnt >= 16'(MIN_GAP))); // R4
    AST_WE_REMOTE:    assert property (@(posedge clk) disable iff (!rst_n) !int_we_n |-> (sel_remote && $past(sel_remote))); // R6
    AST_SW_DROP:      assert property (@(posedge clk) disable iff (!rst_n) $rose(int_we_n) |=> $fell(sel_remote));   // R7
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(sel_remote) |=> ($rose(wr_hold_n) && !bus_req)); // R7
    AST_RDY_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(host_rdy) |-> $rose(wr_hold_n));   // R8
    AST_RDY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !host_rdy |-> !wr_hold_n);                 // R8
endmodule

bind remote_post_write rpw_checker #(.MIN_GAP(MIN_GAP)) i_rpw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rdy   (host_rdy),
    .wr_hold_n  (wr_hold_n),
    .sel_remote (sel_remote),
    .loc_drv_en (loc_drv_en),
    .int_we_n   (int_we_n),
    .bus_req    (bus_req)
);

// File: tb/test_remote_post_write.sv
`timescale 1ns/1ps
module test_remote_post_write;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr_n = 1'b1;
    logic host_req_n = 1'b1;
    logic bus_gnt = 1'b1;
    logic host_rdy, wr_hold_n, sel_remote, loc_drv_en, int_we_n, bus_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    remote_post_write #(.MIN_GAP(GAP), .STROBE_CYC(1)) i_remote_post_write (
        .clk(clk), .rst_n(rst_n), .host_wr_n(host_wr_n), .host_req_n(host_req_n),
        .bus_gnt(bus_gnt), .host_rdy(host_rdy), .wr_hold_n(wr_hold_n),
        .sel_remote(sel_remote), .loc_drv_en(loc_drv_en), .int_we_n(int_we_n),
        .bus_req(bus_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural timeline model
    bit m_busy, m_prev, m_rlow;
    int m_s, m_sw;
    int cyc, hold_falls, rdy_lows, last_rise, gap_after_rise;
    logic prev_hold;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_prev = 1; m_rlow = 0; m_s = 0; m_sw = -1;
        end else begin
            if (m_busy) begin
                if (!host_req_n) m_rlow = 1;
                m_s++;
                if (m_sw < 0 && m_s >= GAP && bus_gnt) m_sw = m_s;
                if (m_sw >= 0 && m_s == m_sw + 4) begin
                    m_busy = 0; m_rlow = 0;
                end
            end else if (!m_prev && host_wr_n) begin
                m_busy = 1; m_s = 0; m_sw = -1;
            end
            m_prev = host_wr_n;
        end
        #1;
        if (rst_n) begin
            cyc++;
            chk("R2/R7 wr_hold_n", wr_hold_n, !m_busy);
            chk("R2/R7 bus_req", bus_req, m_busy);
            chk("R4 sel_remote", sel_remote, m_busy && m_sw >= 0 && m_s < m_sw + 3);
            chk("R5 loc_drv_en", loc_drv_en, !(m_busy && m_sw >= 0 && m_s < m_sw + 3));
            chk("R6 int_we_n", int_we_n, !(m_busy && m_sw >= 0 && m_s == m_sw + 1));
            chk("R8 host_rdy", host_rdy, !m_rlow);
            if (prev_hold && !wr_hold_n) begin
                hold_falls++;
                gap_after_rise = cyc - last_rise;
            end
            if (!prev_hold && wr_hold_n) last_rise = cyc;
            if (!host_rdy) rdy_lows++;
            prev_hold = wr_hold_n;
        end else begin
            prev_hold = 1'b1;
        end
    end

    task automatic post_write(input int len);
        @(negedge clk); host_req_n = 0; host_wr_n = 0;
        repeat (len) @(negedge clk);
        host_wr_n = 1; host_req_n = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 wr_hold_n", wr_hold_n, 1'b1);
        chk("R1 sel_remote", sel_remote, 1'b0);
        chk("R1 loc_drv_en", loc_drv_en, 1'b1);
        chk("R1 int_we_n", int_we_n, 1'b1);
        chk("R1 host_rdy", host_rdy, 1'b1);
        chk("R1 bus_req", bus_req, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // single posted write, grant present: R3
        rdy_lows = 0;
        post_write(2);
        idle(10);
        chk_int("R3 host_rdy low cycles on lone write", rdy_lows, 0);

        // delayed grant stretches the gap: R4
        bus_gnt = 0;
        post_write(1);
        idle(6);
        bus_gnt = 1;
        idle(8);

        // queued access stalled, then completes right after release: R8 R10
        post_write(1);
        idle(1);
        host_req_n = 0; host_wr_n = 0;
        idle(2);
        while (!host_rdy) @(negedge clk);
        host_wr_n = 1; host_req_n = 1;
        idle(12);
        chk_int("R10 edges from hold release to next hold", gap_after_rise, 1);

        // strobe toggled while busy is ignored: R9
        hold_falls = 0;
        post_write(1);
        idle(1);
        host_wr_n = 0; idle(1); host_wr_n = 1;
        idle(12);
        chk_int("R9 transfers started", hold_falls, 1);

        // back-to-back lone writes with gaps of varying length
        for (int k = 0; k < 4; k++) begin
            post_write(k + 1);
            idle(7 + k);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule